// File: doc/BRIEF.md
# Parallel NOR Flash Sequential Reader

This block reads a data stream from an asynchronous parallel NOR flash, one word per address, starting at address 0 and counting upwards. From the system clock it makes a read clock at half the system rate. It drives chip-enable and output-enable low, keeps write-enable high and presents an incrementing address. Each word it captures from the flash data bus is passed on as a one-cycle valid pulse.

The address moves only when the read clock falls, and the data bus is captured only when it rises. This gives the flash half a read period of settling time on every word. The first word gets a longer access window: address 0 is held for several read-clock periods before its data is captured.

When the external DONE input is seen high, reading stops at once. A fixed number of system cycles later, the block releases its flash-facing pins. The pad drivers are turned off through `pins_drive_o`, and the strobes are parked inactive so that board pull-ups can hold them. If the address counter reaches its top value before DONE, it stays there and raises a sticky overflow flag.

Top module: `nor_seq_loader`

## Requirements
- R1: While `rst_n` is low: `rd_clk_o` is 0, all three strobes are 1, the address is 0, `word_valid_o` and `overflow_o` are 0, and `pins_drive_o` is 1.
- R2: From the first system clock edge after reset until release, `rd_clk_o` toggles on every system clock edge, and it rises on the first edge. After release it stays at 0.
- R3: `flash_ce_n_o` and `flash_oe_n_o` always carry the same value. They go low on the first falling read-clock edge, which is system edge 2 after reset. `flash_we_n_o` is 1 at all times.
- R4: Address 0 is held through FIRST_HOLD rising read-clock edges after the strobes go low. Its word is captured on the last of these, at system edge 2*FIRST_HOLD+1.
- R5: After the first word, the address goes up by one on each falling read-clock edge, and the next word is captured on the following rising edge. Word n is therefore valid after system edge 2*FIRST_HOLD+1+2n, with `word_o` equal to the data bus value for address n. The address changes only when `rd_clk_o` goes from 1 to 0.
- R6: `word_valid_o` is high for exactly one system cycle per word, always on a cycle in which `rd_clk_o` has just risen.
- R7: A system clock edge that samples `done_i` high produces no word. No word and no address change follows it. If this happens before the first falling read-clock edge, the strobes never go low.
- R8: `pins_drive_o` falls RELEASE_DLY system edges after the edge that first samples `done_i` high. From then on, `rd_clk_o` is 0, the three strobes are 1, no word is emitted, and this state lasts until reset.
- R9: When the address is at its maximum and another falling read-clock edge arrives before DONE, the address stays at its maximum, `overflow_o` rises, and no further words are emitted. With AW address bits, this falling edge is system edge 2*FIRST_HOLD+2^(AW+1).
- R10: `overflow_o` stays high until reset once set, and it never rises if DONE is sampled before the saturating edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 1 | Load-complete indication; stops reading |
| flash_data_i | input | DATA_W | Flash data bus (8 or 16 bits) |
| rd_clk_o | output | 1 | Read clock at half the system clock rate |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low, held high |
| flash_addr_o | output | ADDR_W | Flash word address |
| pins_drive_o | output | 1 | High while the flash-facing pads are driven; low in user mode |
| word_o | output | DATA_W | Last captured word |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` is new |
| overflow_o | output | 1 | Sticky: address saturated before DONE |

## Verification
A wrong phase or state value shows up at the ports within one or two system cycles. A read clock out of phase moves the address on a rising edge or a capture onto a falling one. A hold counter that is off by one shifts every later word by two edges, so the timestamp check on the very first word catches it. A release counter, or a saturation flag, that misbehaves is caught at the exact edge where `pins_drive_o` or `overflow_o` should change. Leftover state after DONE is caught by any word or address step that follows.

// File: rtl/nor_seq_loader.sv
module nor_seq_loader #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 26,
  parameter int FIRST_HOLD  = 4,
  parameter int RELEASE_DLY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] flash_data_i,
  output logic              rd_clk_o,
  output logic              flash_ce_n_o,
  output logic              flash_oe_n_o,
  output logic              flash_we_n_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              pins_drive_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              overflow_o
);

  localparam int HOLD_W = $clog2(FIRST_HOLD + 1);
  localparam int REL_W  = $clog2(RELEASE_DLY + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(FIRST_HOLD - 1);
  localparam logic [REL_W-1:0]  REL_LAST  = REL_W'(RELEASE_DLY - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP  = {ADDR_W{1'b1}};

  generate
    if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
      $error("DATA_W must be 8 or 16");
    end
    if (FIRST_HOLD < 1 || RELEASE_DLY < 1 || ADDR_W < 1 || ADDR_W > 26) begin : g_bad_cfg
      $error("FIRST_HOLD and RELEASE_DLY must be >= 1, ADDR_W in 1..26");
    end
  endgenerate

  typedef enum logic [2:0] {S_PRE, S_HOLD, S_RUN, S_STOP, S_USER} state_t;

  state_t            st;
  logic              ph;
  logic              strobe_n;
  logic [ADDR_W-1:0] addr_q;
  logic [HOLD_W-1:0] hold_cnt;
  logic [REL_W-1:0]  rel_cnt;
  logic [DATA_W-1:0] word_q;
  logic              vld_q;
  logic              ovf_q;

  wire edge_rise = ~ph;
  wire edge_fall = ph;
  wire loading   = (st == S_PRE) || (st == S_HOLD) || (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PRE;
      ph       <= 1'b0;
      strobe_n <= 1'b1;
      addr_q   <= '0;
      hold_cnt <= '0;
      rel_cnt  <= '0;
      word_q   <= '0;
      vld_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      ph    <= (st == S_USER) ? 1'b0 : ~ph;
      if (loading && done_i) begin
        st      <= S_STOP;
        rel_cnt <= '0;
      end else begin
        case (st)
          S_PRE: begin
            if (edge_fall) begin
              strobe_n <= 1'b0;
              hold_cnt <= '0;
              st       <= S_HOLD;
            end
          end
          S_HOLD: begin
            if (edge_rise) begin
              if (hold_cnt == HOLD_LAST) begin
                word_q <= flash_data_i;
                vld_q  <= 1'b1;
                st     <= S_RUN;
              end else begin
                hold_cnt <= hold_cnt + 1'b1;
              end
            end
          end
          S_RUN: begin
            if (edge_fall) begin
              if (addr_q == ADDR_TOP) ovf_q  <= 1'b1;
              else                    addr_q <= addr_q + 1'b1;
            end else if (!ovf_q) begin
              word_q <= flash_data_i;
              vld_q  <= 1'b1;
            end
          end
          S_STOP: begin
            if (rel_cnt == REL_LAST) begin
              st       <= S_USER;
              ph       <= 1'b0;
              strobe_n <= 1'b1;
            end else begin
              rel_cnt <= rel_cnt + 1'b1;
            end
          end
          default: begin
            ph       <= 1'b0;
            strobe_n <= 1'b1;
          end
        endcase
      end
    end
  end

  assign rd_clk_o     = ph;
  assign flash_ce_n_o = strobe_n;
  assign flash_oe_n_o = strobe_n;
  assign flash_we_n_o = 1'b1;
  assign flash_addr_o = addr_q;
  assign pins_drive_o = (st != S_USER);
  assign word_o       = word_q;
  assign word_valid_o = vld_q;
  assign overflow_o   = ovf_q;

endmodule

module nor_seq_loader_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_clk_o,
  input logic              flash_ce_n_o,
  input logic              flash_oe_n_o,
  input logic              flash_we_n_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic              pins_drive_o,
  input logic              word_valid_o,
  input logic              overflow_o
);

  a_r5_addr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flash_addr_o) |-> ($past(rd_clk_o) && !rd_clk_o));

  a_r6_valid_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (rd_clk_o && !$past(rd_clk_o)));

  a_r3_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    flash_we_n_o);

  a_r3_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ce_n_o == flash_oe_n_o);

  a_r8_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_drive_o |-> (!word_valid_o && !rd_clk_o && flash_ce_n_o));

  a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_drive_o |=> !pins_drive_o);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r9_ovf_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> !word_valid_o);

endmodule

bind nor_seq_loader nor_seq_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_clk_o     (rd_clk_o),
  .flash_ce_n_o (flash_ce_n_o),
  .flash_oe_n_o (flash_oe_n_o),
  .flash_we_n_o (flash_we_n_o),
  .flash_addr_o (flash_addr_o),
  .pins_drive_o (pins_drive_o),
  .word_valid_o (word_valid_o),
  .overflow_o   (overflow_o)
);

// File: tb/nor_seq_loader_tb_top.sv
`timescale 1ns/1ps
module nor_seq_loader_tb_top;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int H  = 4;
  localparam int RD = 2;
  localparam int NWORDS     = 1 << AW;
  localparam int FIRST_EDGE = 2*H + 1;
  localparam int OVF_EDGE   = 2*H + 2*NWORDS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done = 1'b0;
  logic [DW-1:0] fdata;
  logic rd_clk, ce_n, oe_n, we_n, drive, valid, ovf;
  logic [AW-1:0] addr;
  logic [DW-1:0] word;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int cur_k = 0;
  logic [15:0] mseed = 16'h0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nor_seq_loader #(.DATA_W(DW), .ADDR_W(AW), .FIRST_HOLD(H), .RELEASE_DLY(RD)) dut_i (
    .clk(clk), .rst_n(rst_n), .done_i(done), .flash_data_i(fdata),
    .rd_clk_o(rd_clk), .flash_ce_n_o(ce_n), .flash_oe_n_o(oe_n), .flash_we_n_o(we_n),
    .flash_addr_o(addr), .pins_drive_o(drive), .word_o(word),
    .word_valid_o(valid), .overflow_o(ovf));

  function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a, input logic [15:0] s);
    return (16'(a) * 16'h9E37 + 16'h1234) ^ s;
  endfunction

  function automatic int exp_words(input int k);
    int n;
    n = (k > FIRST_EDGE) ? (k - FIRST_EDGE + 1) / 2 : 0;
    return (n > NWORDS) ? NWORDS : n;
  endfunction

  assign fdata = flash_word(addr, mseed);

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, cur_k);
    end
  endtask

  int widx = 0;
  int err_word = 0, err_addr = 0, err_clk = 0, err_strobe = 0, err_rel = 0, err_ovf = 0;
  logic [AW-1:0] p_addr;
  logic p_clk, p_drive, p_ovf;

  always @(negedge clk) begin
    if (!rst_n) begin
      widx = 0; err_word = 0; err_addr = 0; err_clk = 0; err_strobe = 0; err_rel = 0; err_ovf = 0;
    end else begin
      if (valid) begin
        if (cyc != FIRST_EDGE + 2*widx || word != flash_word(AW'(widx), mseed) || int'(addr) != widx)
          err_word++;
        widx++;
      end
      if (addr != p_addr && !(p_clk && !rd_clk)) err_addr++;
      if (drive && p_drive && rd_clk == p_clk) err_clk++;
      if (we_n !== 1'b1 || ce_n !== oe_n) err_strobe++;
      if (cyc == 1 && ce_n !== 1'b1) err_strobe++;
      if (cyc == 2 && ce_n !== (cur_k <= 2)) err_strobe++;
      if (!drive && (rd_clk || valid || !ce_n)) err_rel++;
      if (ovf && !p_ovf && cyc != OVF_EDGE) err_ovf++;
    end
    p_addr = addr; p_clk = rd_clk; p_drive = drive; p_ovf = ovf;
  end

  task automatic run(input int k);
    int nw;
    cur_k = k;
    mseed = 16'($urandom);
    done = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_clk == 0 && ce_n && oe_n && we_n && addr == 0 && !valid && !ovf && drive,
          "R1 reset state", {rd_clk, ce_n, oe_n, we_n, valid, ovf, drive}, 7'b0111001);
    #1 rst_n = 1'b1;
    while (cyc < k - 1) @(negedge clk);
    done = 1'b1;
    while (cyc < k + RD - 1) @(negedge clk);
    check(drive == 1'b1, "R8 drive held before delay", drive, 1);
    @(negedge clk);
    check(drive == 1'b0 && rd_clk == 0 && ce_n && oe_n && we_n, "R8 released at delay",
          {drive, rd_clk, ce_n, oe_n, we_n}, 5'b00111);
    repeat (6) @(negedge clk);
    nw = exp_words(k);
    check(widx == nw, "R7 words before DONE", widx, nw);
    check(ovf == (OVF_EDGE <= k - 1), "R10 overflow flag", ovf, OVF_EDGE <= k - 1);
    check(err_word == 0, "R4/R5 word timing and value", err_word, 0);
    check(err_addr == 0, "R5 address moves on falling edge", err_addr, 0);
    check(err_clk == 0, "R2 read clock toggles", err_clk, 0);
    check(err_strobe == 0, "R3 strobe timing", err_strobe, 0);
    check(err_rel == 0, "R8 quiet after release", err_rel, 0);
    check(err_ovf == 0, "R9 overflow edge", err_ovf, 0);
    if (k > OVF_EDGE)
      check(int'(addr) == NWORDS - 1, "R9 address saturated", addr, NWORDS - 1);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    run(2);
    run(FIRST_EDGE);
    run(FIRST_EDGE + 1);
    run(FIRST_EDGE + 2);
    run(OVF_EDGE);
    run(OVF_EDGE + 1);
    run(150);
    for (int i = 0; i < 10; i++) run(2 + int'($urandom % 120));
    finish_up();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end
endmodule